// File: doc/BRIEF.md
# RMII Dibit Datapath Adapter

This block sits on the MAC side of a reduced-pin Ethernet link and moves data between a four-bit nibble interface and a two-bit line interface. A single 50 MHz reference clock times everything. On the way out, nibbles from the MAC are split into two dibits. On the way in, dibits are merged back into nibbles, each with a valid pulse and an error flag.

A speed input selects the dibit period. In fast mode (100 Mbps) a dibit moves on every reference clock. In slow mode (10 Mbps) a modulo-10 counter makes a strobe, and each dibit is held or sampled only on that strobe, which comes once every ten clocks.

The MAC learns when a nibble is taken from a take strobe that the block drives. The receive side drives a clean data-valid level of its own. It covers only the frame data, without the carrier-sense part that the line's combined carrier/valid signal carries. Looped-back receive data can therefore be fed straight to a transmitter.

Top module: `rmii_dibit_adapter`

## Requirements
- R1: While reset is high and in the first cycle after it, `rmii_tx_en`, `rmii_txd`, `mac_rx_valid`, `rmii_rx_dv` and `mac_rx_er` are all 0.
- R2: With `speed_10m`=0, `mac_tx_take` is high on every second clock. The nibble present on that clock appears on `rmii_txd` as bits [1:0] on the next clock and as bits [3:2] on the clock after.
- R3: With `speed_10m`=1, `mac_tx_take` is high once every 20 clocks. Each transmit dibit is held unchanged for exactly 10 clocks, low pair first.
- R4: `rmii_tx_en` follows the `mac_tx_en` value captured with each nibble. While it is 0, `rmii_txd` is 00.
- R5: The receiver ignores `rmii_rxd` while `rmii_crs_dv` is 0. Dibits other than 01 that arrive after carrier rises are also ignored. The first sampled dibit equal to 01 with `rmii_crs_dv`=1 becomes bits [1:0] of the first nibble, and `rmii_rx_dv` goes to 1 on the next clock.
- R6: Each later pair of sampled dibits forms one nibble, the first dibit in bits [1:0]. `mac_rx_valid` pulses for one clock, on the clock after the second dibit is sampled, with `mac_rxd` holding the nibble.
- R7: `mac_rx_er` goes with a nibble and is 1 if `rmii_rx_er` was 1 when either of that nibble's dibits was sampled.
- R8: A sample with `rmii_crs_dv`=0 during a frame ends the frame. `rmii_rx_dv` falls on the next clock, and a half-received nibble is dropped with no valid pulse.
- R9: With `speed_10m`=1, receive inputs are sampled once per 10 clocks, and a nibble needs 20 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_10m | input | 1 | 1 = ten clocks per dibit, 0 = one clock per dibit |
| mac_tx_en | input | 1 | Transmit enable from the MAC, captured with each nibble |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_tx_take | output | 1 | High on the clock where the nibble inputs are captured |
| rmii_tx_en | output | 1 | Line transmit enable |
| rmii_txd | output | 2 | Line transmit dibit |
| rmii_crs_dv | input | 1 | Line carrier / data-valid |
| rmii_rxd | input | 2 | Line receive dibit |
| rmii_rx_er | input | 1 | Line receive error |
| mac_rx_valid | output | 1 | One-clock pulse per received nibble |
| mac_rxd | output | 4 | Received nibble |
| mac_rx_er | output | 1 | Error flag for the received nibble |
| rmii_rx_dv | output | 1 | Clean receive data-valid level, without carrier sense |

## Verification
A slip in the half-select flop would swap the two dibits of a transmitted nibble. That would show at the pins within two dibit periods of the first enabled nibble. A divider counter off by even one count would change the hold length of the very first slow-mode dibit away from ten clocks. A receive state that fails to enter or leave the frame would show on `rmii_rx_dv` one clock after the deciding sample. It would also show as a missing or extra `mac_rx_valid` pulse within the next nibble time. Nibble values, error flags and the dropped half nibble at the end of a frame are compared pulse by pulse against an expected queue.

// File: rtl/rmii_adapt_pkg.sv
package rmii_adapt_pkg;
  localparam int unsigned DIBIT_W = 2;
  localparam int unsigned NIB_W   = 2 * DIBIT_W;
  localparam logic [DIBIT_W-1:0] START_DIBIT = 2'b01;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rmii_rate_strobe.sv
module rmii_rate_strobe #(
  parameter int unsigned SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_mode,
  output logic dibit_stb,
  output logic half_sel
);
  localparam int unsigned CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || !slow_mode) div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  assign dibit_stb = slow_mode ? (div_cnt == LAST) : 1'b1;

  // half_sel = 0 : next strobe starts a nibble (low pair)
  always_ff @(posedge clk) begin
    if (rst) half_sel <= 1'b0;
    else if (dibit_stb) half_sel <= ~half_sel;
  end

  // R3: divider never leaves its modulo range
  a_r3_div_in_range: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= LAST);
  // R3: slow-mode strobes are never back to back
  a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    (slow_mode && $past(slow_mode) && $past(dibit_stb)) |-> !dibit_stb);
endmodule

// File: rtl/rmii_tx_splitter.sv
module rmii_tx_splitter
  import rmii_adapt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               dibit_stb,
  input  logic               half_sel,
  input  logic               nib_en,
  input  logic [NIB_W-1:0]   nib_data,
  output logic               nib_take,
  output logic               tx_en,
  output logic [DIBIT_W-1:0] txd
);
  logic [DIBIT_W-1:0] hi_pair;

  assign nib_take = dibit_stb & ~half_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en   <= 1'b0;
      txd     <= '0;
      hi_pair <= '0;
    end else if (nib_take) begin
      tx_en   <= nib_en;
      txd     <= nib_en ? nib_data[DIBIT_W-1:0] : '0;
      hi_pair <= nib_en ? nib_data[NIB_W-1:DIBIT_W] : '0;
    end else if (dibit_stb) begin
      txd <= hi_pair;
    end
  end

  // R4: idle line carries zeros
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (txd == '0));
  // R3: outputs only move right after a strobe
  a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !$past(dibit_stb) |-> ($stable(txd) && $stable(tx_en)));
  // R4: enable only changes at a nibble boundary
  a_r4_en_on_nibble: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_en) |-> $past(nib_take));
endmodule

// File: rtl/rmii_rx_merger.sv
module rmii_rx_merger
  import rmii_adapt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               dibit_stb,
  input  logic               crs_dv,
  input  logic [DIBIT_W-1:0] rxd,
  input  logic               rx_er,
  output logic               nib_valid,
  output logic [NIB_W-1:0]   nib_data,
  output logic               nib_err,
  output logic               dv_clean
);
  rx_state_e          state;
  logic               have_lo;
  logic [DIBIT_W-1:0] lo_pair;
  logic               lo_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      have_lo   <= 1'b0;
      lo_pair   <= '0;
      lo_err    <= 1'b0;
      nib_valid <= 1'b0;
      nib_data  <= '0;
      nib_err   <= 1'b0;
    end else begin
      nib_valid <= 1'b0;
      if (dibit_stb) begin
        unique case (state)
          RX_IDLE: begin
            if (crs_dv && rxd == START_DIBIT) begin
              state   <= RX_DATA;
              lo_pair <= rxd;
              lo_err  <= rx_er;
              have_lo <= 1'b1;
            end
          end
          RX_DATA: begin
            if (!crs_dv) begin
              state   <= RX_IDLE;
              have_lo <= 1'b0;
            end else if (!have_lo) begin
              lo_pair <= rxd;
              lo_err  <= rx_er;
              have_lo <= 1'b1;
            end else begin
              nib_data  <= {rxd, lo_pair};
              nib_err   <= lo_err | rx_er;
              nib_valid <= 1'b1;
              have_lo   <= 1'b0;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign dv_clean = (state == RX_DATA);

  // R6: valid is a single-clock pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    nib_valid |=> !nib_valid);
  // R6: nibbles only come out of an open frame
  a_r6_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
    nib_valid |-> $past(state == RX_DATA));
  // R9: every nibble follows a sample strobe
  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    nib_valid |-> $past(dibit_stb));
  // R8: frame closes only on a sampled carrier drop
  a_r8_dv_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(dv_clean) |-> $past(dibit_stb && !crs_dv));
endmodule

// File: rtl/rmii_dibit_adapter.sv
module rmii_dibit_adapter
  import rmii_adapt_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               speed_10m,
  input  logic               mac_tx_en,
  input  logic [NIB_W-1:0]   mac_txd,
  output logic               mac_tx_take,
  output logic               rmii_tx_en,
  output logic [DIBIT_W-1:0] rmii_txd,
  input  logic               rmii_crs_dv,
  input  logic [DIBIT_W-1:0] rmii_rxd,
  input  logic               rmii_rx_er,
  output logic               mac_rx_valid,
  output logic [NIB_W-1:0]   mac_rxd,
  output logic               mac_rx_er,
  output logic               rmii_rx_dv
);
  logic dibit_stb;
  logic half_sel;

  rmii_rate_strobe #(.SLOW_DIV(SLOW_DIV)) rate_i (
    .clk       (clk),
    .rst       (rst),
    .slow_mode (speed_10m),
    .dibit_stb (dibit_stb),
    .half_sel  (half_sel)
  );

  rmii_tx_splitter tx_i (
    .clk       (clk),
    .rst       (rst),
    .dibit_stb (dibit_stb),
    .half_sel  (half_sel),
    .nib_en    (mac_tx_en),
    .nib_data  (mac_txd),
    .nib_take  (mac_tx_take),
    .tx_en     (rmii_tx_en),
    .txd       (rmii_txd)
  );

  rmii_rx_merger rx_i (
    .clk       (clk),
    .rst       (rst),
    .dibit_stb (dibit_stb),
    .crs_dv    (rmii_crs_dv),
    .rxd       (rmii_rxd),
    .rx_er     (rmii_rx_er),
    .nib_valid (mac_rx_valid),
    .nib_data  (mac_rxd),
    .nib_err   (mac_rx_er),
    .dv_clean  (rmii_rx_dv)
  );
endmodule

// File: tb/rmii_dibit_adapter_tb.sv
module rmii_dibit_adapter_tb_top;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_10m = 1'b0;
  logic       mac_tx_en = 1'b0;
  logic [3:0] mac_txd = '0;
  logic       mac_tx_take;
  logic       rmii_tx_en;
  logic [1:0] rmii_txd;
  logic       rmii_crs_dv = 1'b0;
  logic [1:0] rmii_rxd = '0;
  logic       rmii_rx_er = 1'b0;
  logic       mac_rx_valid;
  logic [3:0] mac_rxd;
  logic       mac_rx_er;
  logic       rmii_rx_dv;

  rmii_dibit_adapter dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int per = 1;
  int last_take = -1;
  bit finished = 1'b0;

  int         tx_due_q[$];
  logic [2:0] tx_exp_q[$];
  string      tx_tag_q[$];
  logic [4:0] rx_exp_q[$];
  string      rx_tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // transmit monitor: compare line dibits at their due cycles
  always @(negedge clk) begin
    if (tx_due_q.size() > 0 && tx_due_q[0] == cyc) begin
      int d;
      logic [2:0] e;
      string t;
      d = tx_due_q.pop_front();
      e = tx_exp_q.pop_front();
      t = tx_tag_q.pop_front();
      check({rmii_tx_en, rmii_txd} == e, t, {rmii_tx_en, rmii_txd}, e);
    end
  end

  // receive monitor: compare every nibble pulse with the queue
  always @(negedge clk) begin
    if (mac_rx_valid) begin
      if (rx_exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected nibble", {mac_rx_er, mac_rxd}, 0);
      end else begin
        logic [4:0] e;
        string t;
        e = rx_exp_q.pop_front();
        t = rx_tag_q.pop_front();
        check({mac_rx_er, mac_rxd} == e, t, {mac_rx_er, mac_rxd}, e);
      end
    end
  end

  task automatic wait_take();
    do @(negedge clk); while (!mac_tx_take);
  endtask

  task automatic tx_nibble(bit en, logic [3:0] n, string tag);
    wait_take();
    if (last_take >= 0)
      check(cyc - last_take == 2 * per, tag, cyc - last_take, 2 * per);
    last_take = cyc;
    mac_tx_en = en;
    mac_txd   = n;
    tx_due_q.push_back(cyc + 1);
    tx_exp_q.push_back({en, en ? n[1:0] : 2'b00});
    tx_tag_q.push_back(tag);
    tx_due_q.push_back(cyc + 1 + per);
    tx_exp_q.push_back({en, en ? n[3:2] : 2'b00});
    tx_tag_q.push_back(en ? tag : "R4");
  endtask

  task automatic rx_dibit(bit crs, logic [1:0] d, bit er);
    rmii_crs_dv = crs;
    rmii_rxd    = d;
    rmii_rx_er  = er;
    repeat (per) @(negedge clk);
  endtask

  task automatic rx_nibble(logic [3:0] n, bit er_lo, bit er_hi, string tag);
    rx_exp_q.push_back({er_lo | er_hi, n});
    rx_tag_q.push_back(tag);
    rx_dibit(1'b1, n[1:0], er_lo);
    rx_dibit(1'b1, n[3:2], er_hi);
  endtask

  task automatic do_reset(bit slow);
    rst = 1'b1;
    speed_10m = slow;
    per = slow ? 10 : 1;
    mac_tx_en = 1'b0;
    rmii_crs_dv = 1'b0;
    repeat (3) @(negedge clk);
    check({rmii_tx_en, rmii_txd, mac_rx_valid, rmii_rx_dv, mac_rx_er} == 0, "R1",
          {rmii_tx_en, rmii_txd, mac_rx_valid, rmii_rx_dv, mac_rx_er}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({rmii_tx_en, rmii_rx_dv, mac_rx_valid} == 0, "R1",
          {rmii_tx_en, rmii_rx_dv, mac_rx_valid}, 0);
  endtask

  task automatic run_tx(string tag);
    last_take = -1;
    tx_nibble(1'b1, 4'h5, tag);
    tx_nibble(1'b1, 4'hA, tag);
    tx_nibble(1'b1, 4'h3, tag);
    tx_nibble(1'b1, 4'hC, tag);
    tx_nibble(1'b1, 4'hF, tag);
    tx_nibble(1'b1, 4'h6, tag);
    tx_nibble(1'b0, 4'h7, "R4");
    mac_tx_en = 1'b0;
    repeat (6 * per) @(negedge clk);
    check(tx_due_q.size() == 0, tag, tx_due_q.size(), 0);
  endtask

  task automatic run_rx(string tag);
    wait_take();
    // R5: data with carrier low is ignored
    rx_dibit(1'b0, 2'b01, 1'b0);
    rx_dibit(1'b0, 2'b01, 1'b0);
    check(rmii_rx_dv == 1'b0, "R5", rmii_rx_dv, 0);
    // R5: carrier up with non-start dibits keeps hunting
    rx_dibit(1'b1, 2'b00, 1'b0);
    rx_dibit(1'b1, 2'b10, 1'b0);
    check(rmii_rx_dv == 1'b0, "R5", rmii_rx_dv, 0);
    rx_exp_q.push_back({1'b0, 4'hD});
    rx_tag_q.push_back("R5");
    rx_dibit(1'b1, 2'b01, 1'b0);
    check(rmii_rx_dv == 1'b1, "R5", rmii_rx_dv, 1);
    rx_dibit(1'b1, 2'b11, 1'b0);
    rx_nibble(4'h5, 1'b0, 1'b0, tag);
    rx_nibble(4'h9, 1'b0, 1'b1, "R7");
    rx_nibble(4'hE, 1'b0, 1'b0, tag);
    rx_nibble(4'h2, 1'b1, 1'b0, "R7");
    rx_nibble(4'hB, 1'b0, 1'b0, tag);
    rx_dibit(1'b0, 2'b00, 1'b0);
    check(rmii_rx_dv == 1'b0, "R8", rmii_rx_dv, 0);
    // R8: odd trailing dibit is dropped
    rx_dibit(1'b0, 2'b00, 1'b0);
    rx_nibble(4'h5, 1'b0, 1'b0, tag);
    rx_dibit(1'b1, 2'b11, 1'b1);
    rx_dibit(1'b0, 2'b00, 1'b0);
    check(rmii_rx_dv == 1'b0, "R8", rmii_rx_dv, 0);
    repeat (4 * per) @(negedge clk);
    check(rx_exp_q.size() == 0, "R8", rx_exp_q.size(), 0);
  endtask

  initial begin
    do_reset(1'b0);
    run_tx("R2");
    run_rx("R6");
    do_reset(1'b1);
    run_tx("R3");
    run_rx("R9");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule